// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Fetcher

This block pulls the next buffer request that a driver has posted on a split virtqueue held in memory. When it receives a fetch request, it first reads the driver's published available index. If that index equals the block's own next-available counter, the queue is empty and the block reports that at once. Otherwise it reads the head descriptor index from the available ring. It then follows the linked descriptor chain one descriptor at a time. Every descriptor becomes a segment on an output stream, tagged as device-writable (IN) or device-readable (OUT) and numbered within its own list. When the walk ends, a completion carries a status, the head index (the element id) and the two segment counts.

All ring addresses come from one page frame number input and the compile-time queue size. The descriptor table sits at the page base. The available ring follows it directly. The used ring base is exported, page-aligned, for the logic that completes requests. Memory is reached through a request/response read port that returns one aligned 64-bit little-endian word per request, with one request outstanding at a time.

Back-pressure: the fetch request, the segment stream and the completion each use valid/ready. A valid output keeps its payload unchanged until ready is seen high at a clock edge. The memory request is held in the same way until `mem_req_ready_i` is high. The memory response has no ready, because the block is always waiting for it once a request has been accepted.

Top module: `vq_chain_fetcher`

## Requirements
- R1: Descriptor base is `pfn_i << 12`. Available ring base is descriptor base + 16*QSIZE. `used_base_o` is (available base + 4 + 2*QSIZE) rounded up to a multiple of 4096.
- R2: A fetch first reads the word at the available ring base; bits [31:16] hold the driver index. If this equals the next-available counter, the completion has status EMPTY (1), head 0, both counts 0, no segment is emitted, and the counter is unchanged.
- R3: Otherwise the head index is the 16-bit entry at available base + 4 + 2*(n mod QSIZE), where n is the next-available counter. Within the aligned word, lane ((4+2*(n mod QSIZE))>>1)&3 holds the entry. n then increments by one and wraps at 2^16.
- R4: Descriptor i occupies the 16 bytes at descriptor base + 16*(i mod QSIZE). Word 0 is the buffer address. Word 1 holds length in [31:0], flags in [47:32] and next index in [63:48]. Next values at or above QSIZE wrap by the same modulo.
- R5: Each descriptor is emitted as one segment carrying its address and length. `seg_write_o` is flag bit 1 (1 = IN list, 0 = OUT list). `seg_slot_o` is the number of earlier segments of the same list in this fetch.
- R6: The walk follows the next field while flag bit 0 is set. It stops after the first descriptor without it, with status OK (0), the head index, and the IN and OUT counts.
- R7: Both counts restart at zero on every fetch, so the values from a previous fetch never leak into the next completion.
- R8: If the MAX_SEGS-th segment of a chain still has flag bit 0 set, the walk aborts after emitting it with status LOOP (2), and the counts sum to MAX_SEGS.
- R9: `seg_*` and `done_*` payloads stay stable while valid is high and ready is low.
- R10: A memory request keeps its address until accepted, and a stalled memory port does not change any fetched result.
- R11: After reset `fetch_ready_o` is 1, all valid outputs are 0, and the next-available counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfn_i | input | PFN_W | Queue page frame number |
| used_base_o | output | ADDR_W | Derived used ring base address |
| fetch_valid_i | input | 1 | Fetch request |
| fetch_ready_o | output | 1 | Block idle, request accepted |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | ADDR_W | 8-byte aligned read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data, little-endian |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Segment consumer ready |
| seg_write_o | output | 1 | 1 = IN (device writes), 0 = OUT |
| seg_slot_o | output | CNT_W | Position within its list |
| seg_addr_o | output | 64 | Buffer address |
| seg_len_o | output | 32 | Buffer length |
| done_valid_o | output | 1 | Completion valid |
| done_ready_i | input | 1 | Completion consumer ready |
| done_status_o | output | 2 | 0 OK, 1 EMPTY, 2 LOOP |
| done_head_o | output | 16 | Head descriptor index |
| done_in_cnt_o | output | CNT_W | IN segment count |
| done_out_cnt_o | output | CNT_W | OUT segment count |

## Verification
The main walk is driven with chains of one to MAX_SEGS descriptors. Their write masks are all-OUT, all-IN, mixed and alternating, so a direction swap, a wrong per-list slot or a miscounted list shows up as a segment mismatch. Head positions sit at the table ends. Next fields are deliberately offset by QSIZE, so the descriptor modulo is exercised. The table is replayed three times so the available counter crosses the ring size. One replay runs with the memory port, the segment consumer and the completion consumer all stalling, which separates payload-hold faults from ordering faults. Directed runs then cover an empty queue followed by a normal fetch, which shows whether the counter moved, and a two-descriptor cycle that must stop at the segment limit.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int DESC_BYTES = 16;
  localparam int AVAIL_HDR  = 4;
  localparam int IDX_W      = 16;
  localparam int LEN_W      = 32;
  localparam int WORD_W     = 64;
  localparam int FLG_NEXT   = 0;
  localparam int FLG_WRITE  = 1;

  typedef enum logic [1:0] {
    VQ_OK    = 2'd0,
    VQ_EMPTY = 2'd1,
    VQ_LOOP  = 2'd2
  } vq_status_e;

  typedef enum logic [3:0] {
    F_IDLE, F_RD_AIDX, F_WT_AIDX, F_RD_HEAD, F_WT_HEAD,
    F_RD_D0, F_WT_D0, F_RD_D1, F_WT_D1, F_EMIT, F_DONE
  } fetch_st_e;
endpackage

// File: rtl/vq_ring_addr.sv
module vq_ring_addr
  import vq_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PFN_W      = 32,
  parameter int QSIZE      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [PFN_W-1:0]  pfn,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base
);
  localparam logic [ADDR_W-1:0] PAGE_LOW  = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] TABLE_SZ  = ADDR_W'(DESC_BYTES * QSIZE);
  localparam logic [ADDR_W-1:0] AVAIL_SZ  = ADDR_W'(AVAIL_HDR + 2 * QSIZE);

  logic [ADDR_W-1:0] avail_end;

  always_comb begin
    desc_base  = ADDR_W'(pfn) << PAGE_SHIFT;
    avail_base = desc_base + TABLE_SZ;
    avail_end  = avail_base + AVAIL_SZ;
    used_base  = (avail_end + PAGE_LOW) & ~PAGE_LOW;
  end
endmodule

// File: rtl/vq_seg_sort.sv
module vq_seg_sort #(
  parameter int MAX_SEGS = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             is_write,
  output logic [CNT_W-1:0] in_cnt,
  output logic [CNT_W-1:0] out_cnt,
  output logic [CNT_W-1:0] slot
);
  assign slot = is_write ? in_cnt : out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else if (clr) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else if (take) begin
      if (is_write) in_cnt  <= in_cnt + 1'b1;
      else          out_cnt <= out_cnt + 1'b1;
    end
  end

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (int'(slot) < MAX_SEGS));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_cnt == '0 && out_cnt == '0));
endmodule

// File: rtl/vq_fetch_ctl.sv
module vq_fetch_ctl
  import vq_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int QSIZE    = 16,
  parameter int MAX_SEGS = 8,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] avail_base,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic              seg_write,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic [CNT_W-1:0]  out_cnt,
  output logic              cnt_clr,
  output logic              cnt_take,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [1:0]        done_status,
  output logic [IDX_W-1:0]  done_head
);
  fetch_st_e          st_q;
  logic [IDX_W-1:0]   nxt_avail_q, cur_idx_q, head_q, next_q;
  logic [WORD_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [1:0]         flags_q;
  vq_status_e         status_q;

  logic [31:0]        cur_slot, av_slot, av_off;
  logic [1:0]         av_lane;
  logic [ADDR_W-1:0]  desc_addr, entry_addr;
  logic               last_slot;

  always_comb begin
    cur_slot   = {16'b0, cur_idx_q} % QSIZE;
    av_slot    = {16'b0, nxt_avail_q} % QSIZE;
    av_off     = 32'(AVAIL_HDR) + (av_slot << 1);
    av_lane    = av_off[2:1];
    desc_addr  = desc_base + (ADDR_W'(cur_slot) << 4);
    entry_addr = avail_base + ADDR_W'({av_off[31:3], 3'b000});
    last_slot  = (int'(in_cnt) + int'(out_cnt) + 1) >= MAX_SEGS;
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    unique case (st_q)
      F_RD_AIDX: begin mem_req_valid = 1'b1; mem_req_addr = avail_base; end
      F_RD_HEAD: begin mem_req_valid = 1'b1; mem_req_addr = entry_addr; end
      F_RD_D0:   begin mem_req_valid = 1'b1; mem_req_addr = desc_addr; end
      F_RD_D1:   begin mem_req_valid = 1'b1; mem_req_addr = desc_addr + ADDR_W'(8); end
      default: ;
    endcase
  end

  assign fetch_ready = (st_q == F_IDLE);
  assign seg_valid   = (st_q == F_EMIT);
  assign seg_write   = flags_q[FLG_WRITE];
  assign seg_addr    = addr_q;
  assign seg_len     = len_q;
  assign done_valid  = (st_q == F_DONE);
  assign done_status = status_q;
  assign done_head   = head_q;
  assign cnt_clr     = fetch_ready && fetch_valid;
  assign cnt_take    = seg_valid && seg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      nxt_avail_q <= '0;
      cur_idx_q   <= '0;
      head_q      <= '0;
      next_q      <= '0;
      addr_q      <= '0;
      len_q       <= '0;
      flags_q     <= '0;
      status_q    <= VQ_OK;
    end else begin
      unique case (st_q)
        F_IDLE: if (fetch_valid) begin
          head_q <= '0;
          st_q   <= F_RD_AIDX;
        end
        F_RD_AIDX: if (mem_req_ready) st_q <= F_WT_AIDX;
        F_WT_AIDX: if (mem_rsp_valid) begin
          if (mem_rsp_data[31:16] == nxt_avail_q) begin
            status_q <= VQ_EMPTY;
            st_q     <= F_DONE;
          end else begin
            st_q <= F_RD_HEAD;
          end
        end
        F_RD_HEAD: if (mem_req_ready) st_q <= F_WT_HEAD;
        F_WT_HEAD: if (mem_rsp_valid) begin
          head_q      <= mem_rsp_data[{av_lane, 4'b0000} +: 16];
          cur_idx_q   <= mem_rsp_data[{av_lane, 4'b0000} +: 16];
          nxt_avail_q <= nxt_avail_q + 1'b1;
          st_q        <= F_RD_D0;
        end
        F_RD_D0: if (mem_req_ready) st_q <= F_WT_D0;
        F_WT_D0: if (mem_rsp_valid) begin
          addr_q <= mem_rsp_data;
          st_q   <= F_RD_D1;
        end
        F_RD_D1: if (mem_req_ready) st_q <= F_WT_D1;
        F_WT_D1: if (mem_rsp_valid) begin
          len_q   <= mem_rsp_data[31:0];
          flags_q <= mem_rsp_data[33:32];
          next_q  <= mem_rsp_data[63:48];
          st_q    <= F_EMIT;
        end
        F_EMIT: if (seg_ready) begin
          if (!flags_q[FLG_NEXT]) begin
            status_q <= VQ_OK;
            st_q     <= F_DONE;
          end else if (last_slot) begin
            status_q <= VQ_LOOP;
            st_q     <= F_DONE;
          end else begin
            cur_idx_q <= next_q;
            st_q      <= F_RD_D0;
          end
        end
        F_DONE: if (done_ready) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_write));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_status) && $stable(done_head));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3
  avail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nxt_avail_q == $past(nxt_avail_q) || nxt_avail_q == $past(nxt_avail_q) + 16'd1));
endmodule

// File: rtl/vq_chain_fetcher.sv
module vq_chain_fetcher
  import vq_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PFN_W      = 32,
  parameter int QSIZE      = 16,
  parameter int MAX_SEGS   = 8,
  parameter int PAGE_SHIFT = 12,
  localparam int CNT_W     = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PFN_W-1:0]  pfn_i,
  output logic [ADDR_W-1:0] used_base_o,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic              seg_write_o,
  output logic [CNT_W-1:0]  seg_slot_o,
  output logic [63:0]       seg_addr_o,
  output logic [31:0]       seg_len_o,
  output logic              done_valid_o,
  input  logic              done_ready_i,
  output logic [1:0]        done_status_o,
  output logic [15:0]       done_head_o,
  output logic [CNT_W-1:0]  done_in_cnt_o,
  output logic [CNT_W-1:0]  done_out_cnt_o
);
  logic [ADDR_W-1:0] desc_base, avail_base;
  logic              cnt_clr, cnt_take;

  vq_ring_addr #(
    .ADDR_W(ADDR_W), .PFN_W(PFN_W), .QSIZE(QSIZE), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .pfn(pfn_i), .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base_o)
  );

  vq_seg_sort #(.MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W)) u_sort (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .take(cnt_take), .is_write(seg_write_o),
    .in_cnt(done_in_cnt_o), .out_cnt(done_out_cnt_o), .slot(seg_slot_o)
  );

  vq_fetch_ctl #(
    .ADDR_W(ADDR_W), .QSIZE(QSIZE), .MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .desc_base(desc_base), .avail_base(avail_base),
    .fetch_valid(fetch_valid_i), .fetch_ready(fetch_ready_o),
    .mem_req_valid(mem_req_valid_o), .mem_req_ready(mem_req_ready_i),
    .mem_req_addr(mem_req_addr_o), .mem_rsp_valid(mem_rsp_valid_i),
    .mem_rsp_data(mem_rsp_data_i),
    .seg_valid(seg_valid_o), .seg_ready(seg_ready_i), .seg_write(seg_write_o),
    .seg_addr(seg_addr_o), .seg_len(seg_len_o),
    .in_cnt(done_in_cnt_o), .out_cnt(done_out_cnt_o),
    .cnt_clr(cnt_clr), .cnt_take(cnt_take),
    .done_valid(done_valid_o), .done_ready(done_ready_i),
    .done_status(done_status_o), .done_head(done_head_o)
  );

  // R2
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o && done_status_o == VQ_EMPTY |-> done_in_cnt_o == '0 && done_out_cnt_o == '0 && !seg_valid_o);

  // R8
  loop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o && done_status_o == VQ_LOOP |-> (int'(done_in_cnt_o) + int'(done_out_cnt_o)) == MAX_SEGS);

  // R1
  used_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_base_o[PAGE_SHIFT-1:0] == '0 && used_base_o > avail_base);
endmodule

// File: tb/vq_chain_fetcher_test.sv
module vq_chain_fetcher_test;
  localparam int QS = 16;
  localparam int MAXS = 8;
  localparam logic [63:0] BASE = 64'h2000;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [31:0] pfn_i = 32'd2;
  logic [63:0] used_base_o;
  logic fetch_valid_i = 0, fetch_ready_o;
  logic mem_req_valid_o, mem_req_ready_i = 1;
  logic [63:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 0;
  logic [63:0] mem_rsp_data_i = '0;
  logic seg_valid_o, seg_ready_i = 1, seg_write_o;
  logic [3:0] seg_slot_o;
  logic [63:0] seg_addr_o;
  logic [31:0] seg_len_o;
  logic done_valid_o, done_ready_i = 1;
  logic [1:0] done_status_o;
  logic [15:0] done_head_o;
  logic [3:0] done_in_cnt_o, done_out_cnt_o;

  vq_chain_fetcher uut (.*);

  int total = 0, failed = 0, n_av = 0;
  bit finished = 0, stall_mem = 0;
  logic [63:0] mem [0:63];

  logic        e_dir  [0:31];
  int          e_slot [0:31];
  logic [63:0] e_addr [0:31];
  logic [31:0] e_len  [0:31];

  // head[4] nseg[4] wmask[8] in[4] out[4]
  localparam logic [23:0] VEC [6] = '{
    {4'd3,  4'd1, 8'b0000_0000, 4'd0, 4'd1},
    {4'd5,  4'd3, 8'b0000_0110, 4'd2, 4'd1},
    {4'd0,  4'd4, 8'b0000_1111, 4'd4, 4'd0},
    {4'd15, 4'd2, 8'b0000_0001, 4'd1, 4'd1},
    {4'd9,  4'd5, 8'b0000_0011, 4'd2, 4'd3},
    {4'd12, 4'd8, 8'b1010_1010, 4'd4, 4'd4}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: 1-cycle latency
  always @(posedge clk) begin
    mem_rsp_valid_i <= 1'b0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      mem_rsp_valid_i <= 1'b1;
      if (mem_req_addr_o >= BASE && mem_req_addr_o < BASE + 64'd512)
        mem_rsp_data_i <= mem[(mem_req_addr_o - BASE) >> 3];
      else
        mem_rsp_data_i <= 64'hDEAD_DEAD_DEAD_DEAD;
    end
  end
  always @(negedge clk) mem_req_ready_i <= stall_mem ? ~mem_req_ready_i : 1'b1;

  task automatic put_desc(input int idx, input logic [63:0] a, input logic [31:0] l,
                          input logic [1:0] fl, input logic [15:0] nx);
    mem[idx * 2]     = a;
    mem[idx * 2 + 1] = {nx, 14'd0, fl, l};
  endtask

  task automatic post(input logic [15:0] head);
    int off = 'h104 + 2 * (n_av % QS);
    mem[off >> 3][((off >> 1) & 3) * 16 +: 16] = head;
    mem['h100 >> 3][31:16] = 16'(n_av + 1);
    n_av++;
  endtask

  task automatic build(input int vi, input int head, input int n, input logic [7:0] wm);
    int ic = 0, oc = 0;
    for (int j = 0; j < n; j++) begin
      int d = (head + 7 * j) % QS;
      int dn = (head + 7 * (j + 1)) % QS;
      logic [15:0] nraw = 16'(dn + ((j % 2) ? QS : 0));
      e_dir[j]  = wm[j];
      e_slot[j] = wm[j] ? ic : oc;
      if (wm[j]) ic++; else oc++;
      e_addr[j] = 64'h0000_00AB_0000_0000 | 64'(vi << 16) | 64'(j << 8) | 64'(d);
      e_len[j]  = 32'h100 + 32'(16 * j + vi);
      put_desc(d, e_addr[j], e_len[j], {wm[j], (j < n - 1)}, nraw);
    end
  endtask

  task automatic do_fetch(input string tag, input int en, input logic [1:0] est, input logic [15:0] eh,
                          input int ein, input int eout, input bit bp);
    int j = 0, guard = 0;
    bit stalled = 0, dstall = 0, fin = 0;
    logic [63:0] ha; logic [31:0] hl; logic hw;
    @(negedge clk);
    chk(fetch_ready_o == 1'b1, {tag, " R11 idle ready"}, 64'(fetch_ready_o), 64'd1);
    fetch_valid_i = 1; seg_ready_i = !bp; done_ready_i = !bp; stall_mem = bp;
    @(negedge clk);
    fetch_valid_i = 0;
    while (!fin && guard < 2000) begin
      if (seg_valid_o) begin
        if (bp && !stalled) begin
          stalled = 1; seg_ready_i = 0; ha = seg_addr_o; hl = seg_len_o; hw = seg_write_o;
        end else begin
          if (stalled)
            chk(ha == seg_addr_o && hl == seg_len_o && hw == seg_write_o,
                {tag, " R9 segment held"}, seg_addr_o, ha);
          stalled = 0; seg_ready_i = 1;
          if (j < 32 && j < en) begin
            chk(seg_write_o == e_dir[j], {tag, " R5 direction"}, 64'(seg_write_o), 64'(e_dir[j]));
            chk(int'(seg_slot_o) == e_slot[j], {tag, " R5 slot"}, 64'(seg_slot_o), 64'(e_slot[j]));
            chk(seg_addr_o == e_addr[j], {tag, " R4 address"}, seg_addr_o, e_addr[j]);
            chk(seg_len_o == e_len[j], {tag, " R4 length"}, 64'(seg_len_o), 64'(e_len[j]));
          end
          j++;
        end
      end
      if (done_valid_o) begin
        if (bp && !dstall) begin
          dstall = 1; done_ready_i = 0; ha = 64'({done_status_o, done_head_o});
        end else begin
          if (dstall)
            chk(ha == 64'({done_status_o, done_head_o}), {tag, " R9 completion held"},
                64'({done_status_o, done_head_o}), ha);
          chk(done_status_o == est, {tag, " R6 status"}, 64'(done_status_o), 64'(est));
          chk(done_head_o == eh, {tag, " R3 head"}, 64'(done_head_o), 64'(eh));
          chk(int'(done_in_cnt_o) == ein, {tag, " R7 in count"}, 64'(done_in_cnt_o), 64'(ein));
          chk(int'(done_out_cnt_o) == eout, {tag, " R7 out count"}, 64'(done_out_cnt_o), 64'(eout));
          done_ready_i = 1; fin = 1;
        end
      end
      if (!fin) begin @(negedge clk); guard++; end
    end
    chk(fin, {tag, " R10 completion arrived"}, 64'(fin), 64'd1);
    chk(j == en, {tag, " R6 segment total"}, 64'(j), 64'(en));
    @(negedge clk);
    stall_mem = 0; seg_ready_i = 1; done_ready_i = 1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(fetch_ready_o == 1'b1, "R11 ready after reset", 64'(fetch_ready_o), 64'd1);
    chk(!seg_valid_o && !done_valid_o && !mem_req_valid_o, "R11 valids low in reset",
        64'({seg_valid_o, done_valid_o, mem_req_valid_o}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    // R1 used ring: 0x2000+256+4+32 -> 0x3000
    chk(used_base_o == 64'h3000, "R1 used base", used_base_o, 64'h3000);

    // table, three passes, second with back-pressure (R10, R9)
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 6; v++) begin
        logic [23:0] t = VEC[v];
        build(v, int'(t[23:20]), int'(t[19:16]), t[15:8]);
        post(16'(t[23:20]));
        do_fetch($sformatf("vec%0d pass%0d", v, p), int'(t[19:16]), 2'd0, 16'(t[23:20]),
                 int'(t[7:4]), int'(t[3:0]), p == 1);
      end
    end

    // R2 empty queue: driver index already equals counter
    mem['h100 >> 3][31:16] = 16'(n_av);
    do_fetch("R2 empty", 0, 2'd1, 16'd0, 0, 0, 0);
    // R2 counter unchanged: next fetch uses the same ring slot
    build(1, 5, 3, 8'b0000_0110);
    post(16'd5);
    do_fetch("R2 after empty", 3, 2'd0, 16'd5, 2, 1, 0);

    // R8 cycle 6 <-> 7, both with NEXT, 7 writable
    put_desc(6, 64'hC0DE_0006, 32'h66, 2'b01, 16'd7);
    put_desc(7, 64'hC0DE_0007, 32'h77, 2'b11, 16'd6 + 16'(QS));
    for (int j = 0; j < MAXS; j++) begin
      e_dir[j]  = (j % 2 == 1);
      e_slot[j] = j / 2;
      e_addr[j] = (j % 2) ? 64'hC0DE_0007 : 64'hC0DE_0006;
      e_len[j]  = (j % 2) ? 32'h77 : 32'h66;
    end
    post(16'd6);
    do_fetch("R8 loop", MAXS, 2'd2, 16'd6, 4, 4, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule